// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits inside a host controller's schedule walker. The walker fetches a transfer descriptor, runs the bus transaction, and then needs to know two things: how the descriptor's control word must change, and what to do next. It gives this block the 32-bit control word, the 32-bit token word, a small result code for the transaction and the number of bytes the device returned.

One clock cycle later the block returns several outputs. It gives the rewritten control word and a flag telling whether that word differs from the one fetched, so the walker knows if a write-back is needed. It gives a two-bit interrupt cause mask. It gives a next-step code: advance the queue, skip to the next entry, wait for a pending transaction, or abort the frame. It also raises a bus-error or a process-error flag when either applies.

The same registered output also carries the token fields, decoded for the transaction engine: packet ID, device address, endpoint and maximum length. Memory access, the bus transaction itself and the schedule traversal belong to the surrounding logic.

Top module: `td_status_updater`

## Requirements
- R1: The token is decoded as packet ID = bits 7:0, device address = bits 14:8, endpoint = bits 18:15, and maximum length = (bits 31:21 + 1) modulo 2048. A field value of 0x7FF therefore means a maximum length of 0.
- R2: All outputs are registered. A request accepted on a rising edge with `inValid` high appears after that edge, and `outValid` is high for exactly that one cycle. After reset, `outValid`, `ctrlOut`, `retCode` and `cause` are zero.
- R3: `cause[0]` equals control bit 24 (interrupt on complete) for every request. If control bit 23 (active) is clear, the result is SKIP, the word is unchanged and `changed` is 0, whatever the other inputs are.
- R4: A DATA result (code 0) is a success. The length used is the byte count for IN (PID 0x69) and the maximum length for OUT (0xE1) and SETUP (0x2D). On success, bits 10:0 become (length − 1) modulo 2048, bits 23 and 19 are cleared and `retCode` is ADVANCE (0).
- R5: A successful IN with bit 29 (short-packet detect) set and a length below the maximum sets `cause[1]` and returns SKIP (1) instead of ADVANCE.
- R6: An IN whose byte count exceeds the maximum length is treated as babble, and so is a BABBLE result (code 5). Babble sets bits 20 and 22, clears bit 23, leaves bits 10:0 unchanged and returns ABORT (3).
- R7: TIMEOUT (code 3) and NODEV (code 4) set bit 18. If the error counter in bits 28:27 is nonzero, it is decremented. When the decrement reaches zero, bit 23 is cleared and `usbErr` is raised. The result is SKIP.
- R8: NAK (code 1) sets bit 19 and returns SKIP. For a SETUP packet, a NAK is additionally handled exactly as in R7.
- R9: STALL (code 2) sets bit 22, clears bit 23 and returns SKIP.
- R10: An active descriptor whose packet ID is not SETUP, IN or OUT raises `procErr`, returns ABORT and leaves the word unchanged.
- R11: With bit 25 (isochronous) set on an active descriptor, bit 23 is cleared for every result except PENDING.
- R12: PENDING (code 6) on an active descriptor with a valid PID leaves the word unchanged and returns WAIT (2).
- R13: `changed` is 1 exactly when `ctrlOut` differs from the control word that was supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| ctrlIn | input | 32 | Descriptor control word as fetched |
| tokenIn | input | 32 | Descriptor token word |
| result | input | 3 | Transaction result: 0 DATA, 1 NAK, 2 STALL, 3 TIMEOUT, 4 NODEV, 5 BABBLE, 6 PENDING |
| byteCount | input | CNT_W | Bytes returned by the device (IN only) |
| outValid | output | 1 | Outputs below are valid |
| ctrlOut | output | 32 | Updated control word |
| retCode | output | 2 | 0 ADVANCE, 1 SKIP, 2 WAIT, 3 ABORT |
| cause | output | 2 | Bit 0 completion interrupt, bit 1 short packet |
| changed | output | 1 | Control word needs write-back |
| usbErr | output | 1 | Error counter expired |
| procErr | output | 1 | Invalid packet ID |
| pidOut | output | 8 | Decoded packet ID |
| devAddr | output | 7 | Decoded device address |
| endpoint | output | 4 | Decoded endpoint |
| maxLen | output | 11 | Decoded maximum length |

## Verification
The bound checker enforces several rules on every valid output. The write-back flag must agree with a comparison of the output and input words. A wait must leave the word untouched, and a process error must always come with an abort. Advance must leave active and NAK clear, and any non-process abort must carry babble and stall. An expired error counter must show zero, inactive and timeout, and the completion cause must follow the interrupt bit. The exact bit values are shown only by the directed scenarios: length-minus-one values, including the zero-length wrap; the counter countdown from each starting value; the SETUP NAK fallthrough; short-packet detection; and the isochronous forced deactivation.

// File: rtl/td_upd_pkg.sv
package td_upd_pkg;
  localparam int LEN_W = 11;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  localparam int B_SPD    = 29;
  localparam int B_ERRHI  = 28;
  localparam int B_ERRLO  = 27;
  localparam int B_ISO    = 25;
  localparam int B_IOC    = 24;
  localparam int B_ACTIVE = 23;
  localparam int B_STALL  = 22;
  localparam int B_BABBLE = 20;
  localparam int B_NAK    = 19;
  localparam int B_TMO    = 18;

  typedef enum logic [2:0] {
    RES_DATA    = 3'd0,
    RES_NAK     = 3'd1,
    RES_STALL   = 3'd2,
    RES_TIMEOUT = 3'd3,
    RES_NODEV   = 3'd4,
    RES_BABBLE  = 3'd5,
    RES_PENDING = 3'd6
  } txResult_t;

  typedef enum logic [1:0] {
    NXT_ADVANCE = 2'd0,
    NXT_SKIP    = 2'd1,
    NXT_WAIT    = 2'd2,
    NXT_ABORT   = 2'd3
  } nextStep_t;

  typedef struct packed {
    logic setTimeout;
    logic setNak;
    logic setStall;
    logic setBabble;
    logic clrActive;
    logic clrNak;
    logic loadLen;
    logic decErr;
  } tdStrobe_t;
endpackage

// File: rtl/td_upd_data.sv
module td_upd_data
  import td_upd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [31:0]      ctrlIn,
  input  logic [31:0]      tokenIn,
  input  logic [CNT_W-1:0] byteCount,
  input  tdStrobe_t        strobe,
  output logic [7:0]       pid,
  output logic [6:0]       addr,
  output logic [3:0]       endp,
  output logic [LEN_W-1:0] maxLength,
  output logic             inOverflow,
  output logic             inShort,
  output logic [31:0]      ctrlNext
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] xferLen;
  logic [CNT_W-1:0] maxWide;

  always_comb begin
    pid       = tokenIn[7:0];
    addr      = tokenIn[14:8];
    endp      = tokenIn[18:15];
    maxLength = tokenIn[31:21] + ONE;
    maxWide   = CNT_W'(maxLength);
    inOverflow = byteCount > maxWide;
    inShort    = byteCount < maxWide;
    xferLen    = (pid == PID_IN) ? byteCount[LEN_W-1:0] : maxLength;
  end

  always_comb begin
    ctrlNext = ctrlIn;
    if (strobe.loadLen)    ctrlNext[LEN_W-1:0] = xferLen - ONE;
    if (strobe.setTimeout) ctrlNext[B_TMO] = 1'b1;
    if (strobe.setNak)     ctrlNext[B_NAK] = 1'b1;
    if (strobe.setStall)   ctrlNext[B_STALL] = 1'b1;
    if (strobe.setBabble)  ctrlNext[B_BABBLE] = 1'b1;
    if (strobe.decErr)     ctrlNext[B_ERRHI:B_ERRLO] = ctrlIn[B_ERRHI:B_ERRLO] - 2'd1;
    if (strobe.clrActive)  ctrlNext[B_ACTIVE] = 1'b0;
    if (strobe.clrNak)     ctrlNext[B_NAK] = 1'b0;
  end
endmodule

// File: rtl/td_upd_ctrl.sv
module td_upd_ctrl
  import td_upd_pkg::*;
(
  input  logic [31:0] ctrlIn,
  input  logic [7:0]  pid,
  input  logic [2:0]  result,
  input  logic        inOverflow,
  input  logic        inShort,
  output tdStrobe_t   strobe,
  output nextStep_t   step,
  output logic [1:0]  causeNext,
  output logic        usbErrNext,
  output logic        procErrNext
);
  txResult_t res;
  logic      isIn;
  logic      isSetup;
  logic      pidOk;
  logic      babble;
  logic      doTimeout;
  logic [1:0] errCnt;

  always_comb begin
    res     = txResult_t'(result);
    isIn    = pid == PID_IN;
    isSetup = pid == PID_SETUP;
    pidOk   = isIn || isSetup || (pid == PID_OUT);
    errCnt  = ctrlIn[B_ERRHI:B_ERRLO];
    babble  = (res == RES_BABBLE) || ((res == RES_DATA) && isIn && inOverflow);

    strobe      = '0;
    step        = NXT_SKIP;
    causeNext   = {1'b0, ctrlIn[B_IOC]};
    usbErrNext  = 1'b0;
    procErrNext = 1'b0;
    doTimeout   = 1'b0;

    if (!ctrlIn[B_ACTIVE]) begin
      step = NXT_SKIP;
    end else if (!pidOk) begin
      procErrNext = 1'b1;
      step        = NXT_ABORT;
    end else if (res == RES_PENDING) begin
      step = NXT_WAIT;
    end else begin
      if (ctrlIn[B_ISO]) strobe.clrActive = 1'b1;
      if (babble) begin
        strobe.setBabble = 1'b1;
        strobe.setStall  = 1'b1;
        strobe.clrActive = 1'b1;
        step             = NXT_ABORT;
      end else begin
        unique case (res)
          RES_DATA: begin
            strobe.loadLen   = 1'b1;
            strobe.clrActive = 1'b1;
            strobe.clrNak    = 1'b1;
            if (isIn && ctrlIn[B_SPD] && inShort) begin
              causeNext[1] = 1'b1;
              step         = NXT_SKIP;
            end else begin
              step = NXT_ADVANCE;
            end
          end
          RES_STALL: begin
            strobe.setStall  = 1'b1;
            strobe.clrActive = 1'b1;
          end
          RES_NAK: begin
            strobe.setNak = 1'b1;
            doTimeout     = isSetup;
          end
          default: doTimeout = 1'b1;
        endcase
        if (doTimeout) begin
          strobe.setTimeout = 1'b1;
          strobe.decErr     = errCnt != 2'd0;
          if (errCnt == 2'd1) begin
            strobe.clrActive = 1'b1;
            usbErrNext       = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import td_upd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [31:0]      ctrlIn,
  input  logic [31:0]      tokenIn,
  input  logic [2:0]       result,
  input  logic [CNT_W-1:0] byteCount,
  output logic             outValid,
  output logic [31:0]      ctrlOut,
  output logic [1:0]       retCode,
  output logic [1:0]       cause,
  output logic             changed,
  output logic             usbErr,
  output logic             procErr,
  output logic [7:0]       pidOut,
  output logic [6:0]       devAddr,
  output logic [3:0]       endpoint,
  output logic [LEN_W-1:0] maxLen
);
  tdStrobe_t        strobe;
  nextStep_t        step;
  logic [1:0]       causeNext;
  logic             usbErrNext;
  logic             procErrNext;
  logic [7:0]       pid;
  logic [6:0]       addr;
  logic [3:0]       endp;
  logic [LEN_W-1:0] maxLength;
  logic             inOverflow;
  logic             inShort;
  logic [31:0]      ctrlNext;

  td_upd_data #(.CNT_W(CNT_W)) u_data (
    .ctrlIn(ctrlIn), .tokenIn(tokenIn), .byteCount(byteCount), .strobe(strobe),
    .pid(pid), .addr(addr), .endp(endp), .maxLength(maxLength),
    .inOverflow(inOverflow), .inShort(inShort), .ctrlNext(ctrlNext)
  );

  td_upd_ctrl u_ctrl (
    .ctrlIn(ctrlIn), .pid(pid), .result(result),
    .inOverflow(inOverflow), .inShort(inShort),
    .strobe(strobe), .step(step), .causeNext(causeNext),
    .usbErrNext(usbErrNext), .procErrNext(procErrNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      ctrlOut  <= '0;
      retCode  <= '0;
      cause    <= '0;
      changed  <= 1'b0;
      usbErr   <= 1'b0;
      procErr  <= 1'b0;
      pidOut   <= '0;
      devAddr  <= '0;
      endpoint <= '0;
      maxLen   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        ctrlOut  <= ctrlNext;
        retCode  <= step;
        cause    <= causeNext;
        changed  <= ctrlNext != ctrlIn;
        usbErr   <= usbErrNext;
        procErr  <= procErrNext;
        pidOut   <= pid;
        devAddr  <= addr;
        endpoint <= endp;
        maxLen   <= maxLength;
      end
    end
  end
endmodule

// File: rtl/td_upd_chk.sv
module td_upd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] ctrlIn,
  input logic        outValid,
  input logic [31:0] ctrlOut,
  input logic [1:0]  retCode,
  input logic [1:0]  cause,
  input logic        changed,
  input logic        usbErr,
  input logic        procErr
);
  AST_CHANGED_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (changed == (ctrlOut != $past(ctrlIn)))); // R13

  AST_WAIT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((retCode == 2'd2) -> (ctrlOut == $past(ctrlIn)))); // R12

  AST_PROCERR_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && procErr) |-> (retCode == 2'd3 && !changed)); // R10

  AST_ADVANCE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && retCode == 2'd0) |-> (!ctrlOut[23] && !ctrlOut[19])); // R4

  AST_BABBLE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && retCode == 2'd3 && !procErr) |-> (ctrlOut[20] && ctrlOut[22] && !ctrlOut[23])); // R6

  AST_ERR_EXPIRED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && usbErr) |-> (ctrlOut[28:27] == 2'd0 && !ctrlOut[23] && ctrlOut[18])); // R7

  AST_IOC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (cause[0] == $past(ctrlIn[24]))); // R3

  AST_OUTVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
endmodule

bind td_status_updater td_upd_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .ctrlIn(ctrlIn),
  .outValid(outValid), .ctrlOut(ctrlOut), .retCode(retCode), .cause(cause),
  .changed(changed), .usbErr(usbErr), .procErr(procErr)
);

// File: tb/sim_td_status_updater.sv
`timescale 1ns/1ps
module sim_td_status_updater;
  localparam int CNT_W = 12;
  localparam logic [7:0] P_SETUP = 8'h2D, P_IN = 8'h69, P_OUT = 8'hE1;
  localparam logic [2:0] R_DATA = 0, R_NAK = 1, R_STALL = 2, R_TMO = 3,
                         R_NODEV = 4, R_BAB = 5, R_PEND = 6;
  localparam logic [1:0] ADV = 0, SKP = 1, WAI = 2, ABT = 3;

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic [31:0] ctrlIn = 0, tokenIn = 0;
  logic [2:0] result = 0;
  logic [CNT_W-1:0] byteCount = 0;
  logic outValid, changed, usbErr, procErr;
  logic [31:0] ctrlOut;
  logic [1:0] retCode, cause;
  logic [7:0] pidOut;
  logic [6:0] devAddr;
  logic [3:0] endpoint;
  logic [10:0] maxLen;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  td_status_updater #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrlIn(ctrlIn), .tokenIn(tokenIn),
    .result(result), .byteCount(byteCount), .outValid(outValid), .ctrlOut(ctrlOut),
    .retCode(retCode), .cause(cause), .changed(changed), .usbErr(usbErr),
    .procErr(procErr), .pidOut(pidOut), .devAddr(devAddr), .endpoint(endpoint),
    .maxLen(maxLen)
  );

  function automatic logic [31:0] mkTok(logic [7:0] p, logic [6:0] a, logic [3:0] e, int ml);
    logic [10:0] f;
    f = 11'(ml - 1);
    return {f, 2'b00, e, a, p};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] c, logic [31:0] t, logic [2:0] r, int n);
    @(negedge clk);
    ctrlIn = c; tokenIn = t; result = r; byteCount = CNT_W'(n); inValid = 1;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic expect_out(string tag, logic [31:0] w, logic [1:0] rc, logic [1:0] cs,
                            logic ch, logic ue, logic pe);
    chk({tag, " outValid"}, 32'(outValid), 32'd1);
    chk({tag, " word"}, ctrlOut, w);
    chk({tag, " retCode"}, 32'(retCode), 32'(rc));
    chk({tag, " cause"}, 32'(cause), 32'(cs));
    chk({tag, " changed"}, 32'(changed), 32'(ch));
    chk({tag, " usbErr"}, 32'(usbErr), 32'(ue));
    chk({tag, " procErr"}, 32'(procErr), 32'(pe));
  endtask

  task automatic t_reset;
    chk("R2 reset outValid", 32'(outValid), 0);
    chk("R2 reset word", ctrlOut, 0);
    chk("R2 reset retCode", 32'(retCode), 0);
    chk("R2 reset cause", 32'(cause), 0);
  endtask

  task automatic t_decode;
    apply(32'h0, mkTok(P_IN, 7'h55, 4'hA, 64), R_DATA, 0);
    chk("R1 pid", 32'(pidOut), 32'h69);
    chk("R1 addr", 32'(devAddr), 32'h55);
    chk("R1 endpoint", 32'(endpoint), 32'hA);
    chk("R1 maxLen", 32'(maxLen), 64);
    @(negedge clk);
    chk("R2 single pulse", 32'(outValid), 0);
    apply(32'h0, {11'h7FF, 21'(P_OUT)}, R_DATA, 0);
    chk("R1 maxLen wrap", 32'(maxLen), 0);
  endtask

  task automatic t_success;
    apply(32'h188807FF, mkTok(P_OUT, 7'h1, 4'h1, 8), R_DATA, 3);
    expect_out("R4 OUT ok", 32'h18000007, ADV, 0, 1, 0, 0);
    apply(32'h20800000, mkTok(P_IN, 7'h2, 4'h0, 64), R_DATA, 64);
    expect_out("R4 IN full", 32'h2000003F, ADV, 0, 1, 0, 0);
    apply(32'h00800000, {11'h7FF, 21'(P_IN)}, R_DATA, 0);
    expect_out("R4 IN zero", 32'h000007FF, ADV, 0, 1, 0, 0);
  endtask

  task automatic t_short;
    apply(32'h21800000, mkTok(P_IN, 7'h3, 4'h2, 64), R_DATA, 10);
    expect_out("R5 short", 32'h21000009, SKP, 3, 1, 0, 0);
    apply(32'h01800000, mkTok(P_IN, 7'h3, 4'h2, 64), R_DATA, 10);
    expect_out("R5 no spd", 32'h01000009, ADV, 1, 1, 0, 0);
  endtask

  task automatic t_babble;
    apply(32'h00800000, mkTok(P_IN, 7'h4, 4'h1, 8), R_DATA, 9);
    expect_out("R6 overflow", 32'h00500000, ABT, 0, 1, 0, 0);
    apply(32'h00800003, mkTok(P_OUT, 7'h4, 4'h1, 8), R_BAB, 0);
    expect_out("R6 dev babble", 32'h00500003, ABT, 0, 1, 0, 0);
  endtask

  task automatic t_timeout;
    apply(32'h18800000, mkTok(P_OUT, 7'h5, 4'h1, 8), R_TMO, 0);
    expect_out("R7 err3", 32'h10840000, SKP, 0, 1, 0, 0);
    apply(32'h08800000, mkTok(P_IN, 7'h5, 4'h1, 8), R_NODEV, 0);
    expect_out("R7 err1", 32'h00040000, SKP, 0, 1, 1, 0);
    apply(32'h00800000, mkTok(P_IN, 7'h5, 4'h1, 8), R_TMO, 0);
    expect_out("R7 err0", 32'h00840000, SKP, 0, 1, 0, 0);
  endtask

  task automatic t_nak;
    apply(32'h18800000, mkTok(P_IN, 7'h6, 4'h1, 8), R_NAK, 0);
    expect_out("R8 IN nak", 32'h18880000, SKP, 0, 1, 0, 0);
    apply(32'h10800000, mkTok(P_SETUP, 7'h6, 4'h0, 8), R_NAK, 0);
    expect_out("R8 SETUP nak", 32'h088C0000, SKP, 0, 1, 0, 0);
  endtask

  task automatic t_stall;
    apply(32'h00800000, mkTok(P_OUT, 7'h7, 4'h1, 8), R_STALL, 0);
    expect_out("R9 stall", 32'h00400000, SKP, 0, 1, 0, 0);
  endtask

  task automatic t_badpid;
    apply(32'h01800000, mkTok(8'hA5, 7'h8, 4'h1, 8), R_DATA, 0);
    expect_out("R10 bad pid", 32'h01800000, ABT, 1, 0, 0, 1);
  endtask

  task automatic t_inactive;
    apply(32'h01000005, mkTok(8'hA5, 7'h9, 4'h1, 8), R_STALL, 0);
    expect_out("R3 inactive", 32'h01000005, SKP, 1, 0, 0, 0);
  endtask

  task automatic t_iso;
    apply(32'h02800000, mkTok(P_IN, 7'hA, 4'h1, 8), R_NAK, 0);
    expect_out("R11 iso nak", 32'h02080000, SKP, 0, 1, 0, 0);
  endtask

  task automatic t_pending;
    apply(32'h02800000, mkTok(P_IN, 7'hB, 4'h1, 8), R_PEND, 0);
    expect_out("R12 pending", 32'h02800000, WAI, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset;
    t_decode;
    t_success;
    t_short;
    t_babble;
    t_timeout;
    t_nak;
    t_stall;
    t_badpid;
    t_inactive;
    t_iso;
    t_pending;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule